// File: doc/BRIEF.md
# Forward-Difference Polynomial Motion Evaluator

This block produces one sample of a fifth-order position polynomial for a motion axis on every enabled tick of a step clock. It uses only additions. Six wide accumulators hold the current position and its five forward differences. On each enabled cycle, every accumulator takes in the one above it, and all six update at once from their pre-update values. Because the accumulators are far wider than the position that leaves the block, rounding error stays below one output unit over tens of millions of steps.

A host describes each motion segment through a staging register set. The segment has its forward differences, its step count and, optionally, a starting position. The host writes that set in 32-bit words over a valid/ready stream and then commits it. A committed segment takes over at the same clock edge as the last step of the running segment, so a step clock running every cycle never loses a cycle. If the host gave no position for the new segment, the position carries on from the accumulated value, including any error it has gathered.

Top module: `fdm_eval`

## Requirements
- R1: After reset, `pos` is 0, `pos_valid`, `seg_done` and `busy` are low, and `ld_ready` is high.
- R2: A load word is accepted on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_sel` selects the target: 0 is the start position, 1 to 5 are the first to fifth differences, and 6 is the step count (`ld_word` is ignored for the step count). For the other targets, `ld_word` = w writes bits [32w+31:32w]. `ld_ready` is low from the edge that accepts a commit until the pending segment is taken, and a word offered while `ld_ready` is low is dropped.
- R3: `seg_commit` makes the staged set pending only if the staged step count is nonzero and no segment is already pending. The commit sees the register contents from before any write on the same edge. A commit with a zero count is ignored.
- R4: On each edge where `step_en` is high while `busy` is high, accumulator k becomes accumulator k plus accumulator k+1 for k = 0 to 4, all using their old values. Accumulator 5 holds its value. The sums wrap modulo 2^ACC_W. `pos_valid` is high for the cycle after each such edge.
- R5: `pos` is bits [FRAC_W+POS_W-1:FRAC_W] of accumulator 0. The FRAC_W bits below are fractional.
- R6: `step_en` while `busy` is low changes neither `pos` nor `pos_valid`.
- R7: A segment of count N ends on its N-th evaluation edge. `seg_done` is high for the one cycle after that edge, and `busy` falls then unless a segment was pending.
- R8: A pending segment is taken at the edge of the last step of the running segment. The next enabled cycle already evaluates the new segment, so `busy` stays high and no cycle is lost.
- R9: If no position word was written for the pending segment, accumulator 0 continues from its accumulated value when that segment is taken. If a position word was written, accumulator 0 is replaced by it at the take.
- R10: A segment committed while idle is taken on the edge after the commit is accepted. `busy` rises and no evaluation happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Evaluation enable for this cycle |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Staging set can accept a word |
| ld_sel | input | 3 | Load target: 0 position, 1..5 differences, 6 step count |
| ld_word | input | $clog2(ACC_W/32) | 32-bit word index within the target |
| ld_data | input | 32 | Load word |
| seg_commit | input | 1 | Make the staged segment pending |
| pos | output | POS_W | Integer part of the position accumulator |
| pos_valid | output | 1 | `pos` holds a fresh evaluation |
| seg_done | output | 1 | A segment finished on the previous edge |
| busy | output | 1 | A segment is running |

## Verification
On every cycle, the embedded assertions check these properties: the top difference stays constant except at a take, a pending segment stays frozen until it is taken, a zero-count commit leaves nothing pending, a running segment never has a zero count, and nothing is produced while idle or without an enable. Only the bench scenarios show the position values themselves. They compare each sample against a closed-form binomial sum, so the bench covers the fractional carries, the wraparound of negative differences, and continuity or replacement of the position across back-to-back handovers with gaps in the enable pattern. A dropped write during back-pressure and an ignored zero-count commit become visible only through later outputs.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int BUS_W = 32;
  localparam int NACC  = 6;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_POS = 3'd0,
    SEL_D1  = 3'd1,
    SEL_D2  = 3'd2,
    SEL_D3  = 3'd3,
    SEL_D4  = 3'd4,
    SEL_D5  = 3'd5,
    SEL_CNT = 3'd6
  } ld_sel_e;
endpackage

// File: rtl/fdm_shadow.sv
module fdm_shadow import fdm_pkg::*; #(
  parameter int ACC_W = 192,
  parameter int CNT_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ld_valid,
  output logic                              ld_ready,
  input  logic [SEL_W-1:0]                  ld_sel,
  input  logic [$clog2(ACC_W/BUS_W)-1:0]    ld_word,
  input  logic [BUS_W-1:0]                  ld_data,
  input  logic                              commit,
  input  logic                              take,
  output logic [NACC-1:0][ACC_W-1:0]        sh_acc,
  output logic [CNT_W-1:0]                  sh_cnt,
  output logic                              sh_pos_wr,
  output logic                              sh_valid
);
  localparam int WORDS  = ACC_W / BUS_W;
  localparam int WIDX_W = $clog2(WORDS);

  logic wr;
  logic [ACC_W-1:0] img [NACC];

  assign ld_ready = !sh_valid;
  assign wr       = ld_valid && ld_ready;

  for (genvar k = 0; k < NACC; k++) begin : g_img
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        img[k] <= '0;
      end else if (wr && ld_sel == SEL_W'(k)) begin
        for (int w = 0; w < WORDS; w++) begin
          if (ld_word == WIDX_W'(w)) img[k][w*BUS_W +: BUS_W] <= ld_data;
        end
      end
    end
    assign sh_acc[k] = img[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cnt    <= '0;
      sh_pos_wr <= 1'b0;
      sh_valid  <= 1'b0;
    end else begin
      if (wr && ld_sel == SEL_CNT) sh_cnt <= CNT_W'(ld_data);
      if (wr && ld_sel == SEL_POS) sh_pos_wr <= 1'b1;
      if (take) begin
        sh_valid  <= 1'b0;
        sh_pos_wr <= 1'b0;
      end else if (commit && !sh_valid && sh_cnt != '0) begin
        sh_valid <= 1'b1;
      end
    end
  end

  // R2: a pending segment keeps its contents until it is taken
  p_pending_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && !take) |=> (sh_valid && $stable(sh_cnt) && $stable(sh_acc)));

  // R3: a commit of a zero count leaves nothing pending
  p_zero_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !sh_valid && sh_cnt == '0) |=> !sh_valid);
endmodule

// File: rtl/fdm_cascade.sv
module fdm_cascade import fdm_pkg::*; #(
  parameter int ACC_W  = 192,
  parameter int FRAC_W = 160,
  parameter int POS_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic                       load_diffs,
  input  logic                       load_pos,
  input  logic [NACC-1:0][ACC_W-1:0] sh_acc,
  output logic [POS_W-1:0]           pos
);
  logic [ACC_W-1:0] acc [NACC];

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic ld;
    if (i == 0) begin : g_ld_pos
      assign ld = load_pos;
    end else begin : g_ld_diff
      assign ld = load_diffs;
    end

    if (i < NACC - 1) begin : g_add
      always_ff @(posedge clk) begin
        if (!rst_n)    acc[i] <= '0;
        else if (ld)   acc[i] <= sh_acc[i];
        else if (step) acc[i] <= acc[i] + acc[i+1];
      end
    end else begin : g_top
      always_ff @(posedge clk) begin
        if (!rst_n)  acc[i] <= '0;
        else if (ld) acc[i] <= sh_acc[i];
      end
    end
  end

  assign pos = acc[0][FRAC_W +: POS_W];

  // R4: the highest difference is constant within a segment
  p_top_diff_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_diffs |=> $stable(acc[NACC-1]));
endmodule

// File: rtl/fdm_ctrl.sv
module fdm_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             sh_valid,
  input  logic [CNT_W-1:0] sh_cnt,
  input  logic             sh_pos_wr,
  output logic             take,
  output logic             step,
  output logic             load_diffs,
  output logic             load_pos,
  output logic             pos_valid,
  output logic             seg_done,
  output logic             busy
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             last;

  always_comb begin
    step       = step_en && active;
    last       = step && (cnt == CNT_W'(1));
    take       = sh_valid && (!active || last);
    load_diffs = take;
    load_pos   = take && sh_pos_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      pos_valid <= 1'b0;
      seg_done  <= 1'b0;
    end else begin
      pos_valid <= step;
      seg_done  <= last;
      if (take) begin
        cnt    <= sh_cnt;
        active <= 1'b1;
      end else if (last) begin
        cnt    <= '0;
        active <= 1'b0;
      end else if (step) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign busy = active;

  // R7: a running segment always has steps left
  p_busy_has_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt != '0));

  // R6: nothing is evaluated while idle
  p_idle_no_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pos_valid);
endmodule

// File: rtl/fdm_eval.sv
module fdm_eval import fdm_pkg::*; #(
  parameter int ACC_W  = 192,
  parameter int FRAC_W = 160,
  parameter int POS_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           step_en,
  input  logic                           ld_valid,
  output logic                           ld_ready,
  input  logic [SEL_W-1:0]               ld_sel,
  input  logic [$clog2(ACC_W/BUS_W)-1:0] ld_word,
  input  logic [BUS_W-1:0]               ld_data,
  input  logic                           seg_commit,
  output logic [POS_W-1:0]               pos,
  output logic                           pos_valid,
  output logic                           seg_done,
  output logic                           busy
);
  logic [NACC-1:0][ACC_W-1:0] sh_acc;
  logic [CNT_W-1:0]           sh_cnt;
  logic                       sh_pos_wr, sh_valid;
  logic                       take, step, load_diffs, load_pos;

  fdm_shadow #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_word(ld_word), .ld_data(ld_data),
    .commit(seg_commit), .take(take), .sh_acc(sh_acc), .sh_cnt(sh_cnt),
    .sh_pos_wr(sh_pos_wr), .sh_valid(sh_valid)
  );

  fdm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .sh_valid(sh_valid),
    .sh_cnt(sh_cnt), .sh_pos_wr(sh_pos_wr), .take(take), .step(step),
    .load_diffs(load_diffs), .load_pos(load_pos), .pos_valid(pos_valid),
    .seg_done(seg_done), .busy(busy)
  );

  fdm_cascade #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .POS_W(POS_W)) u_cascade (
    .clk(clk), .rst_n(rst_n), .step(step), .load_diffs(load_diffs),
    .load_pos(load_pos), .sh_acc(sh_acc), .pos(pos)
  );

  // R4: a fresh sample only follows an enabled cycle
  p_valid_after_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid |-> $past(step_en));
endmodule

// File: tb/fdm_eval_tb.sv
`timescale 1ns/1ps
module fdm_eval_tb;
  localparam int ACC_W  = 192;
  localparam int FRAC_W = 160;
  localparam int POS_W  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, ld_valid = 1'b0, seg_commit = 1'b0;
  logic [2:0] ld_sel = '0;
  logic [2:0] ld_word = '0;
  logic [31:0] ld_data = '0;
  logic ld_ready, pos_valid, seg_done, busy;
  logic [POS_W-1:0] pos;

  always #4 clk = ~clk;

  fdm_eval u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_word(ld_word), .ld_data(ld_data),
    .seg_commit(seg_commit), .pos(pos), .pos_valid(pos_valid),
    .seg_done(seg_done), .busy(busy)
  );

  int n_tests = 0, n_fail = 0;
  string cur_req = "R4";
  logic [POS_W-1:0] exp_q [$];

  // host-side image of the staging set, pending copy, and running segment
  logic [ACC_W-1:0] h_d [1:5], p_d [1:5], m_d [1:5];
  logic [ACC_W-1:0] h_pos = '0, p_pos = '0, m_base = '0, m_cur = '0;
  int  h_n = 0, p_n = 0, m_n = 0, m_k = 0;
  bit  h_poswr = 0, p_poswr = 0, p_valid = 0, m_busy = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int binom(input int n, input int k);
    int r = 1;
    if (k > n) return 0;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && pos_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL %s: actual sample %0h expected none", cur_req, pos);
      end else begin
        check(cur_req, 64'(pos), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic cycle(input bit st, input bit cm, input bit lv,
                       input int sel, input int wd, input logic [31:0] dat);
    bit pv0, last, ev, take;
    logic [ACC_W-1:0] val;
    @(negedge clk);
    step_en = st; seg_commit = cm; ld_valid = lv;
    ld_sel = 3'(sel); ld_word = 3'(wd); ld_data = dat;
    if (lv) check("R2", 64'(ld_ready), 64'(!p_valid));
    pv0 = p_valid; last = 0; ev = m_busy && st; val = m_cur;
    if (ev) begin
      m_k++;
      val = m_base;
      for (int j = 1; j <= 5; j++) val = val + m_d[j] * ACC_W'(binom(m_k, j));
      last = (m_k == m_n);
    end
    take = p_valid && (!m_busy || last);
    if (take && p_poswr) val = p_pos;
    if (ev || take) m_cur = val;
    if (ev) exp_q.push_back(val[FRAC_W +: POS_W]);
    if (take) begin
      m_base = m_cur; m_d = p_d; m_k = 0; m_n = p_n; m_busy = 1; p_valid = 0;
    end else if (last) begin
      m_busy = 0;
    end
    if (cm && !pv0 && h_n != 0) begin
      p_valid = 1; p_d = h_d; p_n = h_n; p_poswr = h_poswr; p_pos = h_pos; h_poswr = 0;
    end
    if (lv && !pv0) begin
      if (sel == 0) begin h_pos[wd*32 +: 32] = dat; h_poswr = 1; end
      else if (sel <= 5) h_d[sel][wd*32 +: 32] = dat;
      else h_n = int'(dat);
    end
    @(posedge clk); #2;
    if (last || seg_done) check("R7", 64'(seg_done), 64'(last));
  endtask

  task automatic idle(input int n, input bit st);
    for (int i = 0; i < n; i++) cycle(st, 0, 0, 0, 0, 32'h0);
  endtask
  task automatic wr_acc(input int sel, input logic [ACC_W-1:0] v, input bit st);
    for (int w = 0; w < ACC_W/32; w++) cycle(st, 0, 1, sel, w, v[w*32 +: 32]);
  endtask
  task automatic wr_cnt(input int n, input bit st);
    cycle(st, 0, 1, 6, 0, 32'(n));
  endtask
  task automatic commit(input bit st);
    cycle(st, 1, 0, 0, 0, 32'h0);
  endtask

  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  initial begin
    for (int j = 1; j <= 5; j++) h_d[j] = '0;
    p_d = h_d; m_d = h_d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check("R1", 64'(pos), 64'h0);
    check("R1", 64'({pos_valid, seg_done, busy}), 64'h0);
    check("R1", 64'(ld_ready), 64'h1);

    // R6 enable while idle
    cur_req = "R6";
    idle(3, 1);
    check("R6", 64'({pos, pos_valid}), 64'h0);

    // R3 zero-count commit ignored
    wr_cnt(0, 0);
    commit(0);
    check("R3", 64'(ld_ready), 64'h1);
    idle(2, 0);
    check("R3", 64'(busy), 64'h0);

    // segment A with start position, from idle (R10, R9, R5)
    cur_req = "R5";
    wr_acc(0, 5 * ONE, 0);
    wr_acc(1, 3 * ONE + (ONE >> 1), 0);
    wr_acc(2, 2 * ONE + (ONE >> 3), 0);
    wr_acc(3, ONE, 0);
    wr_acc(4, ONE >> 2, 0);
    wr_acc(5, ONE >> 3, 0);
    wr_cnt(6, 0);
    commit(0);
    check("R2", 64'(ld_ready), 64'h0);
    check("R10", 64'(busy), 64'h0);
    idle(1, 0);
    check("R10", 64'(busy), 64'h1);
    check("R10", 64'({pos_valid, pos}), 64'(5));
    cur_req = "R4";
    idle(6, 1);
    check("R7", 64'(busy), 64'h0);

    // segment B: diffs only, negative first difference, gapped enable (R9 continuity)
    cur_req = "R9";
    wr_acc(1, '0 - 7 * ONE, 0);
    wr_acc(2, ONE << 1, 0);
    wr_acc(3, '0, 0);
    wr_acc(4, '0 - (ONE >> 4), 0);
    wr_acc(5, ONE >> 5, 0);
    wr_cnt(4, 0);
    commit(0);
    idle(1, 0);
    check("R10", 64'(busy), 64'h1);
    cycle(1, 0, 0, 0, 0, 32'h0);
    cycle(0, 0, 0, 0, 0, 32'h0);
    // stage C while B runs: only d1 and count change
    wr_acc(1, ONE + (ONE >> 2), 0);
    wr_cnt(12, 0);
    commit(0);
    // dropped write while pending
    cycle(0, 0, 1, 1, 0, 32'hDEAD_BEEF);
    check("R2", 64'(ld_ready), 64'h0);
    cur_req = "R8";
    cycle(1, 0, 0, 0, 0, 32'h0);
    cycle(0, 0, 0, 0, 0, 32'h0);
    cycle(1, 0, 0, 0, 0, 32'h0);   // B third step
    cycle(1, 0, 0, 0, 0, 32'h0);   // B last step, C taken
    check("R8", 64'(busy), 64'h1);
    check("R8", 64'(ld_ready), 64'h1);
    // stage D with a new position while C runs, stepping throughout
    cur_req = "R9";
    wr_acc(0, 100 * ONE, 1);
    wr_cnt(2, 1);
    commit(1);
    idle(4, 1);                    // C reaches step 12, D replaces position
    check("R9", 64'(busy), 64'h1);
    idle(2, 1);                    // D runs 2 steps
    check("R7", 64'(busy), 64'h0);
    cur_req = "R6";
    idle(3, 1);
    check("R6", 64'(pos_valid), 64'h0);
    idle(2, 0);
    check("R4", 64'(exp_q.size()), 64'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule